// File: doc/BRIEF.md
# Configuration Chain Forwarder

This block sits at the end of a device's configuration path and passes work on to the next device in a daisy chain. It drives one output pin. That pin stays high from reset until the local device reports that it is fully configured and an upstream decoder strobes a forwarding instruction. From then on the pin either carries data to the next device or acts as that device's active-low chip select.

In bypass with a serial source, each bit on the serial input reaches the pin through a single register. In bypass with a parallel source, every accepted byte is serialized least significant bit first. A byte that arrives while an earlier one is still shifting out is dropped and reported as an overrun. In flow-through, which is allowed only with a parallel source, the pin goes low and stays low until reset. The first accepted instruction fixes the mode until the next reset.

Top module: `chain_fwd`

## Requirements
- R1: After reset `chain_out` is 1 and `overrun` is 0, and `chain_out` stays 1 until an instruction is accepted.
- R2: An instruction strobe (`instr_vld`) sampled while `cfg_done` is 0 is ignored: `chain_out` stays 1.
- R3: An instruction is accepted on an edge with `instr_vld`=1 and `cfg_done`=1. `instr_sel`=0 selects bypass, and its source comes from `par_mode` on that edge (0 serial, 1 parallel).
- R4: In serial bypass, `chain_out` during the cycle after edge k equals `ser_in` sampled at edge k (one clock of latency).
- R5: In parallel bypass, a byte is taken on an edge where `par_vld`=1 and no earlier byte is still shifting. Bit 0 appears on `chain_out` after that edge and bit i appears i edges later. `chain_out` is 1 while no byte is shifting.
- R6: A byte presented on the edge after its predecessor's bit 7 appears is accepted, so bytes every 8 cycles leave no gap.
- R7: `par_vld`=1 while a byte is still shifting drops the new byte, leaves the current byte intact, and raises `overrun` for exactly the one cycle after that edge.
- R8: `instr_sel`=1 accepted with `par_mode`=1 selects flow-through. `chain_out` is 0 from the next cycle until reset.
- R9: A flow-through instruction with `par_mode`=0 is ignored: `chain_out` stays 1 and ignores `ser_in`.
- R10: Once a mode is selected, later instruction strobes are ignored until reset.
- R11: `par_vld` outside parallel bypass has no effect: `overrun` stays 0 and `chain_out` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_done | input | 1 | Local device fully configured |
| instr_vld | input | 1 | Forwarding instruction strobe |
| instr_sel | input | 1 | 0 = bypass, 1 = flow-through |
| par_mode | input | 1 | Configuration source: 0 serial, 1 parallel |
| ser_in | input | 1 | Serial configuration data in |
| par_data | input | 8 | Parallel configuration byte |
| par_vld | input | 1 | Byte valid strobe |
| chain_out | output | 1 | Serial data or active-low chip select to the next device |
| overrun | output | 1 | One-cycle pulse when a byte arrives while shifting |

## Verification
The assertions assume that the upstream decoder issues an instruction only as a strobe and that `par_mode` describes the configuration source on the edge where an instruction is taken. They also assume that `ser_in` and `par_vld` are clean synchronous levels. The stimulus changes every input only at the falling clock edge. It sets `par_mode` before each instruction and presents bytes either exactly on the 8-cycle boundary or deliberately inside a shift, so that the overrun case is the only departure from an empty-shifter handoff.

// File: rtl/chain_fwd_pkg.sv
package chain_fwd_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE    = 2'd0,
        MODE_BYP_SER = 2'd1,
        MODE_BYP_PAR = 2'd2,
        MODE_FLOW    = 2'd3
    } fwd_mode_e;
endpackage

// File: rtl/chain_mode_ctrl.sv
module chain_mode_ctrl
    import chain_fwd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cfg_done,
    input  logic      instr_vld,
    input  logic      instr_sel,
    input  logic      par_mode,
    output fwd_mode_e mode
);
    typedef struct packed {
        fwd_mode_e mode;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Only the first qualified strobe after reset selects a mode.
        if (st_q.mode == MODE_IDLE && instr_vld && cfg_done) begin
            if (!instr_sel)
                st_d.mode = par_mode ? MODE_BYP_PAR : MODE_BYP_SER;
            else if (par_mode)
                st_d.mode = MODE_FLOW;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_IDLE};
        else        st_q <= st_d;
    end

    assign mode = st_q.mode;
endmodule

// File: rtl/chain_par_shifter.sv
module chain_par_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DATA_W-1:0] data,
    input  logic              vld,
    output logic              bit_o,
    output logic              overrun
);
    localparam int CW = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [CW-1:0]     left;   // bits still to come after the shown one
        logic              act;    // a bit is currently shown
        logic              bit_v;
        logic              ovr;
    } shf_t;

    shf_t st_d, st_q;
    logic empty;

    assign empty = (st_q.left == '0);

    always_comb begin
        st_d     = st_q;
        st_d.ovr = en && vld && !empty;
        if (en && vld && empty) begin
            st_d.bit_v = data[0];
            st_d.sh    = data >> 1;
            st_d.left  = LAST;
            st_d.act   = 1'b1;
        end else if (!empty) begin
            st_d.bit_v = st_q.sh[0];
            st_d.sh    = st_q.sh >> 1;
            st_d.left  = st_q.left - 1'b1;
            st_d.act   = 1'b1;
        end else begin
            st_d.bit_v = 1'b1;
            st_d.act   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sh: '0, left: '0, act: 1'b0, bit_v: 1'b1, ovr: 1'b0};
        else        st_q <= st_d;
    end

    assign bit_o   = st_q.act ? st_q.bit_v : 1'b1;
    assign overrun = st_q.ovr;
endmodule

// File: rtl/chain_ser_stage.sv
module chain_ser_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic d;
    } ser_t;

    ser_t st_d, st_q;

    always_comb begin
        st_d.d = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{d: 1'b1};
        else        st_q <= st_d;
    end

    assign dout = st_q.d;
endmodule

// File: rtl/chain_fwd.sv
module chain_fwd
    import chain_fwd_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_done,
    input  logic              instr_vld,
    input  logic              instr_sel,
    input  logic              par_mode,
    input  logic              ser_in,
    input  logic [DATA_W-1:0] par_data,
    input  logic              par_vld,
    output logic              chain_out,
    output logic              overrun
);
    fwd_mode_e mode_q;
    logic      ser_q;
    logic      par_bit;
    logic      par_ovr;

    chain_mode_ctrl u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_done  (cfg_done),
        .instr_vld (instr_vld),
        .instr_sel (instr_sel),
        .par_mode  (par_mode),
        .mode      (mode_q)
    );

    chain_ser_stage u_ser (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ser_in),
        .dout  (ser_q)
    );

    chain_par_shifter #(.DATA_W(DATA_W)) u_par (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (mode_q == MODE_BYP_PAR),
        .data    (par_data),
        .vld     (par_vld),
        .bit_o   (par_bit),
        .overrun (par_ovr)
    );

    always_comb begin
        unique case (mode_q)
            MODE_BYP_SER: chain_out = ser_q;
            MODE_BYP_PAR: chain_out = par_bit;
            MODE_FLOW:    chain_out = 1'b0;
            default:      chain_out = 1'b1;
        endcase
    end

    assign overrun = par_ovr;
endmodule

// File: rtl/chain_fwd_chk.sv
module chain_fwd_chk
    import chain_fwd_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cfg_done,
    input logic      ser_in,
    input logic      par_vld,
    input logic      chain_out,
    input logic      overrun,
    input fwd_mode_e mode_q
);
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_IDLE) |-> chain_out);

    assert_no_early_instr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_IDLE && !cfg_done) |=> (mode_q == MODE_IDLE));

    assert_serial_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_BYP_SER) |=> (chain_out == $past(ser_in)));

    assert_ovr_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> ($past(par_vld) && $past(mode_q) == MODE_BYP_PAR));

    assert_flow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_FLOW) |=> (mode_q == MODE_FLOW && !chain_out));

    assert_mode_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_IDLE) |=> $stable(mode_q));

    assert_no_stray_ovr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_BYP_PAR) |-> !overrun);
endmodule

bind chain_fwd chain_fwd_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_done  (cfg_done),
    .ser_in    (ser_in),
    .par_vld   (par_vld),
    .chain_out (chain_out),
    .overrun   (overrun),
    .mode_q    (mode_q)
);

// File: tb/sim_chain_fwd.sv
module sim_chain_fwd;
    localparam int CYC = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_done = 1'b0, instr_vld = 1'b0, instr_sel = 1'b0, par_mode = 1'b0;
    logic       ser_in = 1'b0, par_vld = 1'b0;
    logic [7:0] par_data = '0;
    logic       chain_out, overrun;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CYC/2) clk = ~clk;

    chain_fwd u0 (
        .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .instr_vld(instr_vld),
        .instr_sel(instr_sel), .par_mode(par_mode), .ser_in(ser_in),
        .par_data(par_data), .par_vld(par_vld), .chain_out(chain_out), .overrun(overrun)
    );

    localparam logic [7:0] BYTES [6] = '{8'hA5, 8'h01, 8'h80, 8'h3C, 8'hFF, 8'h00};
    localparam logic [11:0] SER_PAT = 12'b1011_0010_1110;

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cfg_done = 0; instr_vld = 0; instr_sel = 0; par_mode = 0;
        ser_in = 0; par_vld = 0; par_data = '0;
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic issue(input logic sel, input logic pm);
        instr_sel = sel; par_mode = pm; instr_vld = 1'b1;
        tick();
        instr_vld = 1'b0;
    endtask

    initial begin
        #(CYC * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        check("R1 idle out", chain_out, 1'b1);
        check("R1 idle ovr", overrun, 1'b0);

        // Parallel bypass: table walk, back-to-back (R5, R6)
        cfg_done = 1'b1;
        issue(1'b0, 1'b1);
        check("R3/R5 par idle high", chain_out, 1'b1);
        foreach (BYTES[k]) begin
            par_data = BYTES[k]; par_vld = 1'b1;
            tick();
            par_vld = 1'b0;
            check("R6 bit0 no gap", chain_out, BYTES[k][0]);
            for (int i = 1; i < 8; i++) begin
                tick();
                check("R5 bit order", chain_out, BYTES[k][i]);
            end
        end
        tick();
        check("R5 high after last", chain_out, 1'b1);

        // R7 overrun inside a shift
        par_data = 8'h96; par_vld = 1'b1;
        tick();
        check("R5 bit0", chain_out, 1'b0);
        par_data = 8'h69;
        tick();
        par_vld = 1'b0;
        check("R7 ovr pulse", overrun, 1'b1);
        check("R7 byte intact b1", chain_out, 1'b1);
        for (int i = 2; i < 8; i++) begin
            tick();
            check("R7 byte intact", chain_out, logic'(8'h96 >> i));
            if (i == 2) check("R7 ovr one cycle", overrun, 1'b0);
        end
        tick();
        check("R7 dropped byte absent", chain_out, 1'b1);

        // R10 later instruction ignored in parallel bypass
        issue(1'b1, 1'b1);
        check("R10 no flow after bypass", chain_out, 1'b1);

        // Serial bypass (R4), par_vld ignored (R11)
        do_reset();
        cfg_done = 1'b1;
        issue(1'b0, 1'b0);
        for (int i = 0; i < 12; i++) begin
            ser_in = SER_PAT[i];
            tick();
            check("R4 serial latency", chain_out, SER_PAT[i]);
        end
        ser_in = 1'b0; par_vld = 1'b1; par_data = 8'hFF;
        tick();
        par_vld = 1'b0;
        check("R11 no ovr in serial", overrun, 1'b0);
        check("R11 out follows ser", chain_out, 1'b0);

        // R2 and R8 flow-through
        do_reset();
        issue(1'b1, 1'b1);
        check("R2 early instr ignored", chain_out, 1'b1);
        cfg_done = 1'b1;
        par_vld = 1'b1;
        tick();
        par_vld = 1'b0;
        check("R11 par_vld idle no ovr", overrun, 1'b0);
        check("R2 still idle", chain_out, 1'b1);
        issue(1'b1, 1'b1);
        check("R8 flow low", chain_out, 1'b0);
        issue(1'b0, 1'b0);
        check("R10 bypass after flow ignored", chain_out, 1'b0);
        for (int i = 0; i < 20; i++) begin
            ser_in = ~ser_in;
            tick();
        end
        check("R8 stays low", chain_out, 1'b0);

        // R9 flow with serial source ignored
        do_reset();
        cfg_done = 1'b1;
        issue(1'b1, 1'b0);
        ser_in = 1'b0;
        tick();
        check("R9 flow serial ignored", chain_out, 1'b1);
        tick();
        check("R9 no serial data", chain_out, 1'b1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule